// File: doc/BRIEF.md
# Tanimoto Similarity Coprocessor

This block scores how alike two 1024-bit binary fingerprints are. Both fingerprints already sit in a shared dual-port on-chip memory. Each one fills 32 consecutive 32-bit words. A host starts a computation by pushing two word pointers into the engine over a valid/ready command stream. Each stream word carries a flag that marks it as control or data. The engine then reads both vectors itself through its own memory port. It counts the ones in A (a), in B (b) and in A AND B (c), and returns the Tanimoto ratio c/(a+b-c) over a valid/ready result stream.

The result is an unsigned 16-bit fraction equal to floor(S x 65535). A restoring divider produces it, one quotient bit per cycle. When the union of the two vectors is empty, the result is 0xFFFF and no division runs. While a job is running the command stream is back-pressured, so one job is in flight at a time.

Top module: `tanimoto_engine`

## Requirements
- R1: In idle, cmd_ready_o is high. The first control-flagged word (cmd_ctrl_i=1) accepted is the pointer to vector A, and the second is the pointer to vector B.
- R2: A data-flagged word (cmd_ctrl_i=0) offered while a pointer is awaited is consumed and discarded. It starts no memory read and does not change which pointer is awaited next.
- R3: After pointer B is accepted, the engine issues exactly 64 reads on 64 consecutive cycles. Reads alternate A+0, B+0, A+1, B+1 ... A+31, B+31, and addresses wrap modulo the memory size. Read data is taken one cycle after mem_en_o.
- R4: res_data_o equals floor(c x 65535 / (a+b-c)), where a, b and c are the popcounts of A, B and A AND B.
- R5: Identical non-zero vectors give res_data_o = 0xFFFF.
- R6: Two all-zero vectors give res_data_o = 0xFFFF.
- R7: cmd_ready_o stays low from the acceptance of pointer B until the result word is accepted. It returns high in the cycle after that acceptance.
- R8: While res_valid_o is high and res_ready_i is low, res_valid_o stays high and res_data_o stays unchanged.
- R9: After reset, cmd_ready_o is 1, res_valid_o is 0 and mem_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_ready_o | output | 1 | Engine can take a command word |
| cmd_ctrl_i | input | 1 | 1 = control word (pointer), 0 = data word |
| cmd_data_i | input | AW (10) | Word address carried by the command |
| mem_en_o | output | 1 | Memory read enable |
| mem_addr_o | output | AW (10) | Memory word address |
| mem_rdata_i | input | DW (32) | Read data, valid one cycle after mem_en_o |
| res_valid_o | output | 1 | Result word valid |
| res_ready_i | input | 1 | Host takes the result |
| res_data_o | output | QW (16) | Similarity as a 16-bit fraction |

## Verification
A wrong read sequencer shows at the memory port within the 64-cycle burst. It appears as a wrong address, a gap, or a read count other than 64. A wrong accumulator or divider state shows only in the returned word, about 20 cycles after the last read. For that reason the bench compares every result with a popcount computed over its own memory model, using vectors that give all-zero, identical, disjoint and half-overlap counts. Faults in the handshake logic show at once as cmd_ready_o rising during a job, or as the result word changing or dropping under back-pressure.

// File: rtl/tani_pkg.sv
package tani_pkg;
  typedef enum logic [2:0] {
    ST_PTR_A, ST_PTR_B, ST_FETCH, ST_DIV, ST_RESP
  } tani_state_e;
endpackage

// File: rtl/tani_popcnt.sv
module tani_popcnt #(
  parameter int W  = 32,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  in_i,
  output logic [OW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + OW'(in_i[i]);
  end
endmodule

// File: rtl/tani_fetch.sv
module tani_fetch #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int WORDS = 32,
  parameter int CW    = $clog2(WORDS * DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] ptr_a_i,
  input  logic [AW-1:0] ptr_b_i,
  output logic          mem_en_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [CW-1:0] cnt_a_o,
  output logic [CW-1:0] cnt_b_o,
  output logic [CW-1:0] cnt_c_o
);
  localparam int RDS = 2 * WORDS;
  localparam int IW  = $clog2(RDS);
  localparam int PW  = $clog2(DW + 1);

  logic          active, rd_vld, rd_b, rd_last;
  logic [IW-1:0] idx;
  logic [DW-1:0] a_word;
  logic [DW-1:0] pc_in [2];
  logic [PW-1:0] pc_out [2];

  assign pc_in[0] = mem_rdata_i;
  assign pc_in[1] = mem_rdata_i & a_word;

  for (genvar g = 0; g < 2; g++) begin : g_pc
    tani_popcnt #(.W(DW)) u_pc (.in_i(pc_in[g]), .cnt_o(pc_out[g]));
  end

  assign mem_en_o   = active;
  assign mem_addr_o = (idx[0] ? ptr_b_i : ptr_a_i) + AW'(idx[IW-1:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active  <= 1'b0;
      idx     <= '0;
      rd_vld  <= 1'b0;
      rd_b    <= 1'b0;
      rd_last <= 1'b0;
      done_o  <= 1'b0;
      a_word  <= '0;
      cnt_a_o <= '0;
      cnt_b_o <= '0;
      cnt_c_o <= '0;
    end else begin
      rd_vld  <= active;
      rd_b    <= idx[0];
      rd_last <= active && (idx == IW'(RDS - 1));
      done_o  <= rd_vld && rd_last;
      if (start_i) begin
        active  <= 1'b1;
        idx     <= '0;
        cnt_a_o <= '0;
        cnt_b_o <= '0;
        cnt_c_o <= '0;
      end else if (active) begin
        idx <= idx + 1'b1;
        if (idx == IW'(RDS - 1)) active <= 1'b0;
      end
      if (rd_vld && !start_i) begin
        if (!rd_b) begin
          a_word  <= mem_rdata_i;
          cnt_a_o <= cnt_a_o + CW'(pc_out[0]);
        end else begin
          cnt_b_o <= cnt_b_o + CW'(pc_out[0]);
          cnt_c_o <= cnt_c_o + CW'(pc_out[1]);
        end
      end
    end
  end

  AST_AND_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_c_o <= cnt_a_o) && (cnt_c_o <= cnt_b_o)) else $error("AND count exceeds operand count"); // R4
endmodule

// File: rtl/tani_div.sv
module tani_div #(
  parameter int CW = 11,
  parameter int QW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] num_i,
  input  logic [CW-1:0] den_i,
  output logic          done_o,
  output logic [QW-1:0] quo_o
);
  localparam int NW = CW + QW;
  localparam int SW = $clog2(QW);

  logic [NW-1:0] prod;
  logic [CW-1:0] rem, den_q, diff;
  logic [QW-1:0] low;
  logic [SW-1:0] step;
  logic [CW:0]   trial;
  logic          busy, take;

  // numerator scaled by 2^QW-1; top part is already below den since c <= den
  assign prod  = {num_i, {QW{1'b0}}} - NW'(num_i);
  assign trial = {rem, low[QW-1]};
  assign take  = trial >= {1'b0, den_q};
  assign diff  = trial[CW-1:0] - den_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy   <= 1'b0;
      done_o <= 1'b0;
      rem    <= '0;
      low    <= '0;
      den_q  <= '0;
      step   <= '0;
      quo_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        if (den_i == '0) begin
          quo_o  <= '1;
          done_o <= 1'b1;
        end else begin
          busy  <= 1'b1;
          rem   <= prod[NW-1:QW];
          low   <= prod[QW-1:0];
          den_q <= den_i;
          step  <= '0;
          quo_o <= '0;
        end
      end else if (busy) begin
        rem   <= take ? diff : trial[CW-1:0];
        quo_o <= {quo_o[QW-2:0], take};
        low   <= {low[QW-2:0], 1'b0};
        step  <= step + 1'b1;
        if (step == SW'(QW - 1)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_REM_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (rem < den_q)) else $error("partial remainder not below divisor"); // R4
endmodule

// File: rtl/tanimoto_engine.sv
module tanimoto_engine
  import tani_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int WORDS = 32,
  parameter int QW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_ctrl_i,
  input  logic [AW-1:0] cmd_data_i,
  output logic          mem_en_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          res_valid_o,
  input  logic          res_ready_i,
  output logic [QW-1:0] res_data_o
);
  localparam int CW = $clog2(WORDS * DW + 1);

  tani_state_e   st;
  logic [AW-1:0] ptr_a, ptr_b;
  logic [CW-1:0] cnt_a, cnt_b, cnt_c, den;
  logic          fetch_start, fetch_done, div_start, div_done, ptr_hit;

  assign cmd_ready_o = (st == ST_PTR_A) || (st == ST_PTR_B);
  assign ptr_hit     = cmd_valid_i && cmd_ctrl_i;
  assign fetch_start = (st == ST_PTR_B) && ptr_hit;
  assign div_start   = (st == ST_FETCH) && fetch_done;
  assign den         = cnt_a + cnt_b - cnt_c;
  assign res_valid_o = (st == ST_RESP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= ST_PTR_A;
      ptr_a <= '0;
      ptr_b <= '0;
    end else begin
      unique case (st)
        ST_PTR_A: if (ptr_hit) begin ptr_a <= cmd_data_i; st <= ST_PTR_B; end
        ST_PTR_B: if (ptr_hit) begin ptr_b <= cmd_data_i; st <= ST_FETCH; end
        ST_FETCH: if (fetch_done) st <= ST_DIV;
        ST_DIV:   if (div_done) st <= ST_RESP;
        ST_RESP:  if (res_ready_i) st <= ST_PTR_A;
        default:  st <= ST_PTR_A;
      endcase
    end
  end

  tani_fetch #(.AW(AW), .DW(DW), .WORDS(WORDS), .CW(CW)) u_fetch (
    .clk_i, .rst_ni,
    .start_i(fetch_start),
    .ptr_a_i(ptr_a),
    .ptr_b_i(ptr_b),
    .mem_en_o, .mem_addr_o, .mem_rdata_i,
    .done_o(fetch_done),
    .cnt_a_o(cnt_a), .cnt_b_o(cnt_b), .cnt_c_o(cnt_c)
  );

  tani_div #(.CW(CW), .QW(QW)) u_div (
    .clk_i, .rst_ni,
    .start_i(div_start),
    .num_i(cnt_c),
    .den_i(den),
    .done_o(div_done),
    .quo_o(res_data_o)
  );

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o))) else $error("result dropped"); // R8
  AST_NO_CMD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o || mem_en_o) |-> !cmd_ready_o) else $error("command taken while busy"); // R7
  AST_DATA_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_PTR_A) && cmd_valid_i && !cmd_ctrl_i) |=> ((st == ST_PTR_A) && !mem_en_o)) else $error("data word not dropped"); // R2
endmodule

// File: tb/sim_tanimoto_engine.sv
`timescale 1ns/1ps
module sim_tanimoto_engine;
  localparam int AW = 10;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ctrl = 1'b0, res_ready = 1'b0;
  logic [AW-1:0] cmd_data = '0;
  logic cmd_ready, mem_en, res_valid;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [15:0] res_data;
  logic [31:0] mem [MSZ];

  int n_chk = 0, n_bad = 0;
  int cyc = 0, rd_n = 0, addr_err = 0, first_cyc = 0, last_cyc = 0;
  logic [AW-1:0] exp_pa = '0, exp_pb = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (mem_en) mem_rdata <= mem[mem_addr];

  tanimoto_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_ctrl_i(cmd_ctrl), .cmd_data_i(cmd_data),
    .mem_en_o(mem_en), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_data_o(res_data)
  );

  // read monitor for R3
  always @(negedge clk) if (mem_en) begin
    logic [AW-1:0] ea;
    ea = (rd_n % 2 == 1 ? exp_pb : exp_pa) + AW'(rd_n / 2);
    if (ea != mem_addr) addr_err++;
    if (rd_n == 0) first_cyc = cyc;
    last_cyc = cyc;
    rd_n++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int expect_s(input logic [AW-1:0] pa, input logic [AW-1:0] pb);
    int a = 0, b = 0, c = 0, d;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] wa, wb;
      wa = mem[(int'(pa) + i) % MSZ];
      wb = mem[(int'(pb) + i) % MSZ];
      a += $countones(wa);
      b += $countones(wb);
      c += $countones(wa & wb);
    end
    d = a + b - c;
    if (d == 0) return 'hFFFF;
    return (c * 65535) / d;
  endfunction

  task automatic fill(input int base, input int kind, input int seed);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      case (kind)
        0: w = 32'h0;
        1: w = 32'hFFFF_FFFF;
        2: w = 32'h5555_5555;
        3: w = 32'hAAAA_AAAA;
        4: w = 32'h0000_FFFF;
        default: w = (32'(seed) * 32'h9E37_79B9) ^ (32'(i) * 32'h85EB_CA6B) ^ (32'(seed + i) << 7);
      endcase
      mem[(base + i) % MSZ] = w;
    end
  endtask

  task automatic copy_vec(input int src, input int dst);
    for (int i = 0; i < 32; i++) mem[(dst + i) % MSZ] = mem[(src + i) % MSZ];
  endtask

  task automatic send_word(input logic ctrl, input logic [AW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ctrl = ctrl; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_ctrl = 1'b0;
  endtask

  // one job; junk=1 slips a data word between the pointers; hold=cycles of back-pressure
  task automatic run_pair(input string tag, input int pa, input int pb, input int exp_val,
                          input bit junk, input int hold);
    int t, exp_calc;
    logic [15:0] first;
    exp_calc = expect_s(AW'(pa), AW'(pb));
    check(exp_calc == exp_val, {tag, " bench model R4"}, exp_calc, exp_val);
    exp_pa = AW'(pa); exp_pb = AW'(pb); rd_n = 0; addr_err = 0;
    send_word(1'b1, AW'(pa));
    if (junk) begin
      send_word(1'b0, AW'(pb + 5));
      check(rd_n == 0, {tag, " R2 data word started reads"}, rd_n, 0);
    end
    send_word(1'b1, AW'(pb));
    check(cmd_ready == 1'b0, {tag, " R7 ready during job"}, int'(cmd_ready), 0);
    t = 0;
    while (!res_valid && t < 500) begin @(negedge clk); t++; end
    check(rd_n == 64, {tag, " R3 read count"}, rd_n, 64);
    check(addr_err == 0, {tag, " R3 address order"}, addr_err, 0);
    check(last_cyc - first_cyc == 63, {tag, " R3 burst span"}, last_cyc - first_cyc, 63);
    check(res_valid == 1'b1, {tag, " R4 result valid"}, int'(res_valid), 1);
    check(int'(res_data) == exp_val, {tag, " R4 result"}, int'(res_data), exp_val);
    first = res_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(res_valid && res_data == first, {tag, " R8 hold"}, int'(res_data), int'(first));
      check(cmd_ready == 1'b0, {tag, " R7 ready while result pending"}, int'(cmd_ready), 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid && cmd_ready, {tag, " R7 ready after accept"}, int'(cmd_ready), 1);
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R9 reset ready", int'(cmd_ready), 1);
    check(res_valid == 1'b0, "R9 reset res_valid", int'(res_valid), 0);
    check(mem_en == 1'b0, "R9 reset mem_en", int'(mem_en), 0);
  endtask

  task automatic t_drop_idle();
    rd_n = 0;
    send_word(1'b0, AW'(7));
    repeat (5) @(negedge clk);
    check(rd_n == 0, "R2 idle data word reads", rd_n, 0);
    check(cmd_ready && !res_valid, "R2 idle stays idle", int'(cmd_ready), 1);
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drop_idle();

    fill(0, 5, 11);   copy_vec(0, 100);
    run_pair("identical R5", 0, 100, 'hFFFF, 1'b0, 0);
    run_pair("same pointer R5", 0, 0, 'hFFFF, 1'b0, 0);
    fill(200, 0, 0);  fill(300, 0, 0);
    run_pair("both zero R6", 200, 300, 'hFFFF, 1'b0, 0);
    run_pair("one zero R4", 0, 200, 0, 1'b0, 0);
    fill(400, 2, 0);  fill(450, 3, 0);
    run_pair("disjoint R4", 400, 450, 0, 1'b0, 0);
    fill(500, 1, 0);  fill(550, 4, 0);
    run_pair("half R4", 500, 550, 32767, 1'b0, 0);
    fill(600, 5, 3);  fill(650, 5, 4);
    run_pair("mixed R2 junk", 600, 650, expect_s(AW'(600), AW'(650)), 1'b1, 0);
    run_pair("backpressure R8", 600, 650, expect_s(AW'(600), AW'(650)), 1'b0, 12);
    fill(1010, 5, 9); fill(700, 5, 21);
    run_pair("wrap R3", 1010, 700, expect_s(AW'(1010), AW'(700)), 1'b0, 0);
    fill(750, 2, 0);
    run_pair("ones vs alt R4", 500, 750, 32767, 1'b0, 3);
    run_pair("reverse order R1", 650, 600, expect_s(AW'(650), AW'(600)), 1'b0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule